// File: doc/BRIEF.md
# Multiplexed Strobe-Bus Register Slave

This block is the register-access end of a narrow control bus on which address and data share one set of lines. The host first places an address on the lines and pulses an address strobe. It then either places data on the lines and pulses a write strobe, or lets go of the lines and pulses a read strobe. While the read strobe is active the slave drives the read word back and raises an output enable, which the pad ring uses to turn the shared lines around. All three strobes are asynchronous to the slave clock. Each one passes through a synchronizer and an edge detector, so that every pulse yields exactly one latch, write or read event.

The address space has two regions. The lower region holds per-channel pin-electronics words, laid out as one block per channel with three timing sets in each block. The slave keeps these words in a memory that can be read back. The upper region is a small global space whose meaning depends on direction. A write there updates control words that appear on output ports. A read there returns status words taken from input ports. The same address can therefore name two unrelated registers.

Top module: `strobe_reg_slave`

## Requirements
- R1: A synchronous active-high reset clears every global control output to zero, drops bus_oe, and makes every per-channel word read back as zero until it is next written.
- R2: The address latch loads bus_in on the synchronized rising edge of adr_stb and holds that value through any number of later write or read pulses.
- R3: A write pulse stores bus_in in the per-channel word at address ch*24 + set*8 + k (ch 0..15, set 0..2, k 0..6). A later read of that address returns all 10 bits.
- R4: The format word of channel ch sits at address ch*24 + 15. It keeps bus_in bits 4:0 only, and bits 9:5 read as zero.
- R5: The I/O control word of channel ch sits at address ch*24 + 7. Bits 4:1 are written from bus_in. Bit 0 always reads phase_early[ch], and a write to it has no effect. Bits 9:5 read as zero.
- R6: A write to global address 180h + n updates one control output, chosen by n: 0 loop_addr, 1 end_addr, 2 xram_addr, 3 xram_ctl, 4..7 the four 10-bit slices of ram_wdata (n=4 is bits 9:0), 8 dram_ctl. The control outputs change at no other time.
- R7: A read of global address 180h + n returns an input, chosen by n: 0 dbg_word, 1 vec_ptr, 2 hist_ptr, 3 cmd_word, 4..7 the four slices of ram_rdata (n=4 is bits 9:0). A write to the same address does not alter what the read returns.
- R8: Reads of unmapped addresses return zero. These are offset 23 of any channel block, 188h, and 189h to 3FFh. Writes to unmapped addresses change no control output and no per-channel word.
- R9: bus_oe is high only while a synchronized read strobe is active. It rises no later than four clock edges after rd_stb rises and falls within four edges after rd_stb falls. It stays low during address and write pulses.
- R10: bus_in is sampled once per strobe pulse, at the synchronized rising edge. Changes to bus_in later in the same pulse do not cause a second latch or a second write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | 10 | Shared address/data lines, inbound |
| bus_out | output | 10 | Read data driven onto the shared lines |
| bus_oe | output | 1 | Output enable for the shared lines |
| adr_stb | input | 1 | Address strobe, asynchronous |
| wr_stb | input | 1 | Write strobe, asynchronous |
| rd_stb | input | 1 | Read strobe, asynchronous |
| phase_early | input | 16 | Per-channel phase-compare status bit |
| dbg_word | input | 10 | Debug status word |
| vec_ptr | input | 10 | Current vector memory address |
| hist_ptr | input | 10 | Current history memory address |
| cmd_word | input | 10 | Current command word |
| ram_rdata | input | 40 | Four external memory read words |
| loop_addr | output | 10 | Loop address control word |
| end_addr | output | 10 | End address control word |
| xram_addr | output | 10 | External memory address word |
| xram_ctl | output | 10 | External memory control word |
| ram_wdata | output | 40 | Four external memory write words |
| dram_ctl | output | 10 | Dynamic memory control word |

## Verification
Every per-channel word can be seen only through a read on the bus. A corrupted address latch, a lost valid bit or a wrong write mask therefore shows up in the bus_out word of the next read, four clock edges after its read strobe rises. A global control word written with the wrong slot shows up on the control output ports one edge after the write event. The bench reads the other control outputs back as well, to catch a write that lands in the wrong slot. A strobe that fires twice, or a bus_oe that lingers, shows up in the mid-pulse data-change tests and in the turn-around checks made after each read.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic [1:0] {PE_NONE, PE_TIMING, PE_IOCTL, PE_FORMAT} pe_kind_e;

  localparam int RAM_WORDS    = 4;
  // global write slots
  localparam int WS_LOOP      = 0;
  localparam int WS_END       = 1;
  localparam int WS_XADDR     = 2;
  localparam int WS_XCTL      = 3;
  localparam int WS_WD0       = 4;
  localparam int WS_DRAM      = WS_WD0 + RAM_WORDS;
  localparam int GLB_WR_SLOTS = WS_DRAM + 1;
  // global read slots
  localparam int RS_DBG       = 0;
  localparam int RS_VEC       = 1;
  localparam int RS_HIST      = 2;
  localparam int RS_CMD       = 3;
  localparam int RS_RD0       = 4;
  localparam int GLB_RD_SLOTS = RS_RD0 + RAM_WORDS;

  localparam int FMT_BITS     = 5;
  localparam int IOCTL_BITS   = 5;
endpackage

// File: rtl/srs_strobe_sync.sv
module srs_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic rise,
  output logic held
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], strobe};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
  assign held = chain[STAGES];

  // R10
  single_evt_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/srs_decode.sv
module srs_decode import srs_pkg::*; #(
  parameter  int AW         = 10,
  parameter  int NCH        = 16,
  parameter  int NSETS      = 3,
  parameter  int SET_STRIDE = 8,
  localparam int CH_STRIDE  = NSETS * SET_STRIDE,
  localparam int PE_WORDS   = NCH * CH_STRIDE,
  localparam int CHW        = $clog2(NCH),
  localparam int SW         = $clog2(GLB_WR_SLOTS)
) (
  input  logic [AW-1:0]  addr,
  output pe_kind_e       kind,
  output logic [CHW-1:0] ch,
  output logic           glb_wr_hit,
  output logic           glb_rd_hit,
  output logic [SW-1:0]  glb_slot
);
  int a_i, off_i, set_i, pos_i, g_i;

  assign a_i   = int'(addr);
  assign off_i = a_i % CH_STRIDE;
  assign set_i = off_i / SET_STRIDE;
  assign pos_i = off_i % SET_STRIDE;
  assign g_i   = a_i - PE_WORDS;

  always_comb begin
    kind = PE_NONE;
    if (a_i < PE_WORDS && set_i < NSETS) begin
      if (pos_i != SET_STRIDE - 1) kind = PE_TIMING;
      else if (set_i == 0)         kind = PE_IOCTL;
      else if (set_i == 1)         kind = PE_FORMAT;
    end
  end

  assign ch         = CHW'(a_i / CH_STRIDE);
  assign glb_wr_hit = (g_i >= 0) && (g_i < GLB_WR_SLOTS);
  assign glb_rd_hit = (g_i >= 0) && (g_i < GLB_RD_SLOTS);
  assign glb_slot   = SW'(g_i);
endmodule

// File: rtl/srs_pe_store.sv
module srs_pe_store #(
  parameter  int DW    = 10,
  parameter  int DEPTH = 384,
  localparam int PAW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [PAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic           re,
  input  logic [PAW-1:0] raddr,
  output logic [DW-1:0]  rdata,
  output logic           rvalid
);
  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] vld;

  // plain memory, no reset, so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

  // written-since-reset flags give the zero-after-reset view
  always_ff @(posedge clk) begin
    if (rst) begin
      vld    <= '0;
      rvalid <= 1'b0;
    end else begin
      if (we) vld[waddr] <= 1'b1;
      if (re) rvalid <= vld[raddr];
    end
  end
endmodule

// File: rtl/strobe_reg_slave.sv
module strobe_reg_slave import srs_pkg::*; #(
  parameter  int DW          = 10,
  parameter  int NCH         = 16,
  parameter  int NSETS       = 3,
  parameter  int SET_STRIDE  = 8,
  parameter  int SYNC_STAGES = 2,
  localparam int CH_STRIDE   = NSETS * SET_STRIDE,
  localparam int PE_WORDS    = NCH * CH_STRIDE,
  localparam int PAW         = $clog2(PE_WORDS),
  localparam int CHW         = $clog2(NCH),
  localparam int SW          = $clog2(GLB_WR_SLOTS),
  localparam int RSW         = $clog2(GLB_RD_SLOTS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [DW-1:0]         bus_in,
  output logic [DW-1:0]         bus_out,
  output logic                  bus_oe,
  input  logic                  adr_stb,
  input  logic                  wr_stb,
  input  logic                  rd_stb,
  input  logic [NCH-1:0]        phase_early,
  input  logic [DW-1:0]         dbg_word,
  input  logic [DW-1:0]         vec_ptr,
  input  logic [DW-1:0]         hist_ptr,
  input  logic [DW-1:0]         cmd_word,
  input  logic [RAM_WORDS*DW-1:0] ram_rdata,
  output logic [DW-1:0]         loop_addr,
  output logic [DW-1:0]         end_addr,
  output logic [DW-1:0]         xram_addr,
  output logic [DW-1:0]         xram_ctl,
  output logic [RAM_WORDS*DW-1:0] ram_wdata,
  output logic [DW-1:0]         dram_ctl
);
  // ---- strobe synchronizers: index 0 address, 1 write, 2 read
  logic [2:0] stb_in, stb_rise, stb_held;
  assign stb_in = {rd_stb, wr_stb, adr_stb};

  for (genvar gi = 0; gi < 3; gi++) begin : g_sync
    srs_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .strobe(stb_in[gi]),
      .rise(stb_rise[gi]), .held(stb_held[gi])
    );
  end

  logic adr_ev, wr_ev, rd_ev;
  logic [1:0] unused_held;
  assign adr_ev      = stb_rise[0];
  assign wr_ev       = stb_rise[1];
  assign rd_ev       = stb_rise[2];
  assign unused_held = stb_held[1:0];

  // ---- address latch
  logic [DW-1:0] addr_q;
  always_ff @(posedge clk) begin
    if (rst)         addr_q <= '0;
    else if (adr_ev) addr_q <= bus_in;
  end

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adr_ev |=> $stable(addr_q));

  // ---- decode
  pe_kind_e       kind;
  logic [CHW-1:0] ch;
  logic           glb_wr_hit, glb_rd_hit;
  logic [SW-1:0]  glb_slot;

  srs_decode #(.AW(DW), .NCH(NCH), .NSETS(NSETS), .SET_STRIDE(SET_STRIDE)) u_dec (
    .addr(addr_q), .kind(kind), .ch(ch),
    .glb_wr_hit(glb_wr_hit), .glb_rd_hit(glb_rd_hit), .glb_slot(glb_slot)
  );

  // ---- per-channel words, masked on the way in
  logic [DW-1:0] pe_wdata, pe_rdata;
  logic          pe_rvalid;

  always_comb begin
    pe_wdata = bus_in;
    if (kind == PE_FORMAT)     pe_wdata = DW'(bus_in[FMT_BITS-1:0]);
    else if (kind == PE_IOCTL) pe_wdata = DW'({bus_in[IOCTL_BITS-1:1], 1'b0});
  end

  srs_pe_store #(.DW(DW), .DEPTH(PE_WORDS)) u_store (
    .clk(clk), .rst(rst),
    .we(wr_ev && kind != PE_NONE), .waddr(addr_q[PAW-1:0]), .wdata(pe_wdata),
    .re(rd_ev), .raddr(addr_q[PAW-1:0]),
    .rdata(pe_rdata), .rvalid(pe_rvalid)
  );

  // ---- global write-side control words
  logic [DW-1:0] glb_w [GLB_WR_SLOTS];
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < GLB_WR_SLOTS; i++) glb_w[i] <= '0;
    end else if (wr_ev && glb_wr_hit) begin
      glb_w[glb_slot] <= bus_in;
    end
  end

  assign loop_addr = glb_w[WS_LOOP];
  assign end_addr  = glb_w[WS_END];
  assign xram_addr = glb_w[WS_XADDR];
  assign xram_ctl  = glb_w[WS_XCTL];
  assign dram_ctl  = glb_w[WS_DRAM];

  // ---- global read-side status words
  logic [DW-1:0] glb_r [GLB_RD_SLOTS];
  assign glb_r[RS_DBG]  = dbg_word;
  assign glb_r[RS_VEC]  = vec_ptr;
  assign glb_r[RS_HIST] = hist_ptr;
  assign glb_r[RS_CMD]  = cmd_word;

  for (genvar gi = 0; gi < RAM_WORDS; gi++) begin : g_ramw
    assign ram_wdata[gi*DW +: DW] = glb_w[WS_WD0 + gi];
    assign glb_r[RS_RD0 + gi]     = ram_rdata[gi*DW +: DW];
  end

  // ---- read path: capture on the event, drive one edge later
  logic           rd_pend;
  pe_kind_e       rd_kind_q;
  logic [CHW-1:0] rd_ch_q;
  logic [DW-1:0]  rd_glb_q, rd_word;

  always_comb begin
    case (rd_kind_q)
      PE_TIMING, PE_FORMAT: rd_word = pe_rvalid ? pe_rdata : '0;
      PE_IOCTL: begin
        rd_word    = pe_rvalid ? pe_rdata : '0;
        rd_word[0] = phase_early[rd_ch_q];
      end
      default: rd_word = rd_glb_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend   <= 1'b0;
      rd_kind_q <= PE_NONE;
      rd_ch_q   <= '0;
      rd_glb_q  <= '0;
      bus_out   <= '0;
      bus_oe    <= 1'b0;
    end else begin
      rd_pend <= rd_ev;
      bus_oe  <= stb_held[2];
      if (rd_ev) begin
        rd_kind_q <= kind;
        rd_ch_q   <= ch;
        rd_glb_q  <= glb_rd_hit ? glb_r[glb_slot[RSW-1:0]] : '0;
      end
      if (rd_pend) bus_out <= rd_word;
    end
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (loop_addr == '0 && end_addr == '0 && xram_addr == '0 &&
                    xram_ctl == '0 && ram_wdata == '0 && dram_ctl == '0 && !bus_oe));

  // R6
  glb_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_ev)) |->
      $stable({loop_addr, end_addr, xram_addr, xram_ctl, ram_wdata, dram_ctl}));

  // R8
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ev && !glb_wr_hit) |=>
      $stable({loop_addr, end_addr, xram_addr, xram_ctl, ram_wdata, dram_ctl}));

  // R9
  oe_src_chk: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> $past(stb_held[2]));
endmodule

// File: tb/strobe_reg_slave_tb.sv
module strobe_reg_slave_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  bus_in = '0;
  logic [9:0]  bus_out;
  logic        bus_oe;
  logic        adr_stb = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
  logic [15:0] phase_early = '0;
  logic [9:0]  dbg_word = '0, vec_ptr = '0, hist_ptr = '0, cmd_word = '0;
  logic [39:0] ram_rdata = '0;
  logic [9:0]  loop_addr, end_addr, xram_addr, xram_ctl, dram_ctl;
  logic [39:0] ram_wdata;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_reg_slave dut_i (
    .clk(clk), .rst(rst), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .adr_stb(adr_stb), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .phase_early(phase_early), .dbg_word(dbg_word), .vec_ptr(vec_ptr),
    .hist_ptr(hist_ptr), .cmd_word(cmd_word), .ram_rdata(ram_rdata),
    .loop_addr(loop_addr), .end_addr(end_addr), .xram_addr(xram_addr),
    .xram_ctl(xram_ctl), .ram_wdata(ram_wdata), .dram_ctl(dram_ctl)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_addr(input logic [9:0] a);
    bus_in  = a;
    adr_stb = 1'b1;
    repeat (4) @(negedge clk);
    adr_stb = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic strobe_wr(input logic [9:0] d);
    bus_in = d;
    wr_stb = 1'b1;
    repeat (4) @(negedge clk);
    wr_stb = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic strobe_rd(output logic [9:0] d, output logic oe_mid, output logic oe_after);
    bus_in = 10'h3C3;
    rd_stb = 1'b1;
    repeat (4) @(negedge clk);
    d      = bus_out;
    oe_mid = bus_oe;
    rd_stb = 1'b0;
    repeat (5) @(negedge clk);
    oe_after = bus_oe;
  endtask

  task automatic bus_write(input logic [9:0] a, input logic [9:0] d);
    set_addr(a);
    strobe_wr(d);
  endtask

  task automatic bus_read(input logic [9:0] a, output logic [9:0] d);
    logic m, f;
    set_addr(a);
    strobe_rd(d, m, f);
  endtask

  function automatic logic [69:0] glb_snapshot();
    return {loop_addr, end_addr, xram_addr, xram_ctl, ram_wdata, dram_ctl};
  endfunction

  task automatic t_reset();
    logic [9:0] d;
    check("R1 control outputs after reset", glb_snapshot(), 70'h0);
    check("R1 bus_oe after reset", bus_oe, 1'b0);
    bus_read(10'd3*24 + 10'd10, d);
    check("R1 unwritten channel word", d, 10'h000);
  endtask

  task automatic t_timing_rw();
    logic [9:0] d;
    bus_write(10'd0, 10'h2A5);
    bus_write(10'd382, 10'h3FF);
    bus_write(10'd179, 10'h155);
    bus_read(10'd0, d);   check("R3 ch0 set0 k0", d, 10'h2A5);
    bus_read(10'd382, d); check("R3 ch15 set2 k6", d, 10'h3FF);
    bus_read(10'd179, d); check("R3 ch7 set1 k3", d, 10'h155);
  endtask

  task automatic t_addr_hold();
    logic [9:0] d1, d2;
    logic m, f;
    set_addr(10'd179);
    strobe_rd(d1, m, f);
    strobe_rd(d2, m, f);
    check("R2 first read of held address", d1, 10'h155);
    check("R2 second read of held address", d2, 10'h155);
    strobe_wr(10'h0F0);
    strobe_rd(d1, m, f);
    check("R2 write reuses held address", d1, 10'h0F0);
  endtask

  task automatic t_format();
    logic [9:0] d;
    bus_write(10'd135, 10'h3FF);
    bus_read(10'd135, d);
    check("R4 format keeps bits 4:0", d, 10'h01F);
    bus_write(10'd15, 10'h2EA);
    bus_read(10'd15, d);
    check("R4 format ch0", d, 10'h00A);
  endtask

  task automatic t_ioctl();
    logic [9:0] d;
    phase_early = 16'h0004;
    bus_write(10'd55, 10'h3FF);
    bus_read(10'd55, d);
    check("R5 ioctl ch2 with status set", d, 10'h01F);
    bus_write(10'd103, 10'h3FF);
    bus_read(10'd103, d);
    check("R5 ioctl ch4 status clear, bit0 write ignored", d, 10'h01E);
    bus_write(10'd79, 10'h001);
    bus_read(10'd79, d);
    check("R5 ioctl ch3 written bit0 only", d, 10'h000);
  endtask

  task automatic t_glb_write();
    for (int n = 0; n < 9; n++) bus_write(10'h180 + 10'(n), 10'h101 + 10'(n));
    check("R6 loop_addr", loop_addr, 10'h101);
    check("R6 end_addr", end_addr, 10'h102);
    check("R6 xram_addr", xram_addr, 10'h103);
    check("R6 xram_ctl", xram_ctl, 10'h104);
    check("R6 ram_wdata", ram_wdata, {10'h108, 10'h107, 10'h106, 10'h105});
    check("R6 dram_ctl", dram_ctl, 10'h109);
  endtask

  task automatic t_glb_read();
    logic [9:0] d;
    dbg_word  = 10'h11F;
    vec_ptr   = 10'h2A0;
    hist_ptr  = 10'h0F0;
    cmd_word  = 10'h35A;
    ram_rdata = {10'h0D4, 10'h0C3, 10'h0B2, 10'h0A1};
    bus_read(10'h180, d); check("R7 debug word, split from loop write", d, 10'h11F);
    bus_read(10'h181, d); check("R7 vector pointer", d, 10'h2A0);
    bus_read(10'h182, d); check("R7 history pointer", d, 10'h0F0);
    bus_read(10'h183, d); check("R7 command word", d, 10'h35A);
    bus_read(10'h184, d); check("R7 ram read word 0", d, 10'h0A1);
    bus_read(10'h186, d); check("R7 ram read word 2", d, 10'h0C3);
  endtask

  task automatic t_unmapped();
    logic [9:0] d;
    logic [69:0] snap;
    bus_write(10'd46, 10'h2C2);
    bus_write(10'd47, 10'h123);
    bus_read(10'd47, d);  check("R8 channel offset 23 reads zero", d, 10'h000);
    bus_read(10'd46, d);  check("R8 neighbour untouched", d, 10'h2C2);
    bus_read(10'd48, d);  check("R8 next channel word 0 untouched", d, 10'h000);
    bus_read(10'h188, d); check("R8 read of 188h", d, 10'h000);
    bus_read(10'h200, d); check("R8 read of 200h", d, 10'h000);
    snap = glb_snapshot();
    bus_write(10'h1F0, 10'h3FF);
    bus_write(10'h189, 10'h3FF);
    check("R8 unmapped global writes ignored", glb_snapshot(), snap);
  endtask

  task automatic t_oe();
    logic [9:0] d;
    logic m, f;
    set_addr(10'd0);
    bus_in = 10'h111;
    wr_stb = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 bus_oe low during write", bus_oe, 1'b0);
    wr_stb = 1'b0;
    repeat (5) @(negedge clk);
    strobe_rd(d, m, f);
    check("R9 bus_oe high during read", m, 1'b1);
    check("R9 bus_oe low after read", f, 1'b0);
    check("R9 read data", d, 10'h111);
  endtask

  task automatic t_single_evt();
    logic [9:0] d;
    logic m, f;
    bus_in  = 10'd0;
    adr_stb = 1'b1;
    repeat (6) @(negedge clk);
    bus_in  = 10'd179;
    repeat (4) @(negedge clk);
    adr_stb = 1'b0;
    repeat (5) @(negedge clk);
    strobe_rd(d, m, f);
    check("R10 address sampled once per pulse", d, 10'h111);
    bus_in = 10'h011;
    wr_stb = 1'b1;
    repeat (6) @(negedge clk);
    bus_in = 10'h022;
    repeat (4) @(negedge clk);
    wr_stb = 1'b0;
    repeat (5) @(negedge clk);
    strobe_rd(d, m, f);
    check("R10 write data sampled once per pulse", d, 10'h011);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_timing_rw();
    t_addr_hold();
    t_format();
    t_ioctl();
    t_glb_write();
    t_glb_read();
    t_unmapped();
    t_oe();
    t_single_evt();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule